// File: doc/BRIEF.md
# Interrupt Group Distributor Registers

This block is the register front end that an interrupt distributor uses to decide which interrupt lines belong to which group and whether each group may be forwarded at all. A byte-wide register bus reaches a control byte, a read-only type byte and a bank of group-assignment bytes. The control byte holds an enable for group 0, an enable for group 1 and an enable that routes group-0 interrupts to the fast-interrupt output. The prioritisation logic downstream reads the three enables and a vector with one group bit per interrupt line.

A revision parameter selects the feature set. From revision 2 on, the split enables and the group bits are stored. Below revision 2, only a single distributor enable (control bit 0) exists, and the group bytes read as zero and drop writes. Reads are combinational from the address. Writes land on the rising clock edge at which the write strobe is high.

Top module: `irq_grp_dist_regs`

## Requirements
- R1: After a synchronous reset the group-0, group-1 and fast-interrupt enables are low, every line is in group 0 (`line_group` all zero), and the control byte reads 0.
- R2: At revision 2 or later, a write to byte 0x000 stores bit 0 as the group-0 enable, bit 1 as the group-1 enable and bit 3 as the fast-interrupt enable. All three drive their outputs and read back at the same positions, and every other bit of the byte reads 0.
- R3: Below revision 2, a write to byte 0x000 stores only bit 0. The group-1 and fast-interrupt outputs stay low, and the control byte reads back only bit 0.
- R4: Byte 0x004 reads the line count divided by 32, minus one, in bits 4:0 and the core count minus one in bits 7:5. Writes to it change nothing.
- R5: Bytes 0x001 to 0x003 and 0x005 to 0x007 read 0, and writes to them leave the control byte unchanged.
- R6: At revision 2 or later, bit i of byte 0x080+n holds the group of line 8n+i (1 = group 1, 0 = group 0). It appears on `line_group[8n+i]` and reads back at the same bit.
- R7: Below revision 2, the group bytes read 0 and writes to them leave `line_group` at zero.
- R8: A group byte whose first line 8n is at or above the line count reads 0 and raises `bus_err`. A write to it changes no output.
- R9: Read data follows the address in the same cycle. A write becomes visible at the outputs only after the clock edge that carries the strobe.
- R10: `bus_err` stays low for the control byte, the type byte and group bytes that cover existing lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| bus_err | output | 1 | Access to a group byte beyond the line count |
| grp0_en | output | 1 | Group-0 forwarding enable |
| grp1_en | output | 1 | Group-1 forwarding enable |
| fiq_en | output | 1 | Route group 0 to the fast-interrupt output |
| line_group | output | NUM_LINES | Group bit per interrupt line |

## Verification
All state in the block sits directly on an output. A corrupted enable or group bit therefore shows on `grp0_en`, `grp1_en`, `fiq_en` or `line_group` in the cycle after the write that caused it, and shows on `bus_rdata` as soon as the byte is addressed. A wrong address decode shows as a byte landing in the wrong eight lines, a reserved or out-of-range write disturbing an output, or `bus_err` being raised for a legal byte. Each of these shows one edge after the stimulus. A legacy-revision instance runs beside the default one on the same bus, so any leak of the group features into it shows on the same edge.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

  // Byte offsets decoded by the register block
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_TYPE = 4;
  localparam int unsigned GRP_IDX_W = 7;   // group region spans 128 bytes from 0x80

  typedef struct packed {
    logic g0;
    logic g1;
    logic fiq;
  } dist_en_t;

  // Type byte: (lines/32 - 1) in [4:0], (cores - 1) in [7:5]
  function automatic logic [7:0] type_word(input int unsigned lines, input int unsigned cores);
    logic [7:0] v;
    v[4:0] = 5'((lines / 32) - 1);
    v[7:5] = 3'(cores - 1);
    return v;
  endfunction

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]                  addr,
  output logic                               hit_ctrl,
  output logic                               hit_type,
  output logic                               hit_grp,
  output logic [irq_grp_pkg::GRP_IDX_W-1:0]  grp_idx
);
  import irq_grp_pkg::*;

  localparam int unsigned UPPER_W = ADDR_W - GRP_IDX_W;

  always_comb begin
    hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    hit_type = (addr == ADDR_W'(OFS_TYPE));
    hit_grp  = (addr[ADDR_W-1:GRP_IDX_W] == UPPER_W'(1));
    grp_idx  = addr[GRP_IDX_W-1:0];
  end

endmodule

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl #(
  parameter int unsigned REVISION = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [7:0]            wdata,
  output irq_grp_pkg::dist_en_t en,
  output logic [7:0]            rd
);
  import irq_grp_pkg::*;

  generate
    if (REVISION >= 2) begin : g_split
      dist_en_t en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q <= '0;
        end else if (wr) begin
          en_q.g0  <= wdata[0];
          en_q.g1  <= wdata[1];
          en_q.fiq <= wdata[3];
        end
      end
      assign en = en_q;
    end else begin : g_single
      logic g0_q;
      always_ff @(posedge clk) begin
        if (rst)     g0_q <= 1'b0;
        else if (wr) g0_q <= wdata[0];
      end
      assign en = '{g0: g0_q, g1: 1'b0, fiq: 1'b0};
    end
  endgenerate

  assign rd = {4'b0000, en.fiq, 1'b0, en.g1, en.g0};

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(en)); // R5
  AST_CTRL_G0_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr |=> (en.g0 == $past(wdata[0]))); // R2
  AST_LEGACY_ONLY_G0: assert property (@(posedge clk) disable iff (rst)
    (REVISION < 2) |-> (!en.g1 && !en.fiq)); // R3

endmodule

// File: rtl/irq_grp_bank.sv
module irq_grp_bank #(
  parameter int unsigned REVISION  = 2,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr,
  input  logic                                hit,
  input  logic [irq_grp_pkg::GRP_IDX_W-1:0]   idx,
  input  logic [7:0]                          wdata,
  output logic [7:0]                          rd,
  output logic                                err,
  output logic [NUM_LINES-1:0]                line_group
);
  import irq_grp_pkg::*;

  localparam int unsigned NUM_BYTES = NUM_LINES / 8;
  localparam logic [GRP_IDX_W:0] BYTES_LIM = (GRP_IDX_W + 1)'(NUM_BYTES);

  logic       in_range;
  logic [7:0] grp_q [NUM_BYTES];

  assign in_range = hit && ({1'b0, idx} < BYTES_LIM);
  assign err      = hit && !in_range;

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      if (REVISION >= 2) begin : g_store
        always_ff @(posedge clk) begin
          if (rst)
            grp_q[b] <= 8'h00;
          else if (wr && in_range && (idx == GRP_IDX_W'(b)))
            grp_q[b] <= wdata;
        end

        AST_GRP_WRITE: assert property (@(posedge clk) disable iff (rst)
          (wr && in_range && idx == GRP_IDX_W'(b)) |=> (line_group[b*8 +: 8] == $past(wdata))); // R6
        AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
          !(wr && in_range && idx == GRP_IDX_W'(b)) |=> $stable(line_group[b*8 +: 8])); // R8
      end else begin : g_razwi
        assign grp_q[b] = 8'h00;

        AST_GRP_LEGACY_ZERO: assert property (@(posedge clk) disable iff (rst)
          1'b1 |-> (line_group[b*8 +: 8] == 8'h00)); // R7
      end
      assign line_group[b*8 +: 8] = grp_q[b];
    end
  endgenerate

  always_comb begin
    rd = 8'h00;
    for (int b = 0; b < NUM_BYTES; b++)
      if (in_range && idx == GRP_IDX_W'(b)) rd = grp_q[b];
  end

endmodule

// File: rtl/irq_grp_dist_regs.sv
module irq_grp_dist_regs #(
  parameter int unsigned REVISION  = 2,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 bus_err,
  output logic                 grp0_en,
  output logic                 grp1_en,
  output logic                 fiq_en,
  output logic [NUM_LINES-1:0] line_group
);
  import irq_grp_pkg::*;

  localparam logic [7:0] TYPE_VAL = type_word(NUM_LINES, NUM_CORES);

  logic                 hit_ctrl, hit_type, hit_grp;
  logic [GRP_IDX_W-1:0] grp_idx;
  logic [7:0]           ctrl_rd, grp_rd;
  dist_en_t             en;

  irq_grp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr     (bus_addr),
    .hit_ctrl (hit_ctrl),
    .hit_type (hit_type),
    .hit_grp  (hit_grp),
    .grp_idx  (grp_idx)
  );

  irq_grp_ctrl #(.REVISION(REVISION)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr && hit_ctrl),
    .wdata (bus_wdata),
    .en    (en),
    .rd    (ctrl_rd)
  );

  irq_grp_bank #(.REVISION(REVISION), .NUM_LINES(NUM_LINES)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .hit        (hit_grp),
    .idx        (grp_idx),
    .wdata      (bus_wdata),
    .rd         (grp_rd),
    .err        (bus_err),
    .line_group (line_group)
  );

  assign grp0_en = en.g0;
  assign grp1_en = en.g1;
  assign fiq_en  = en.fiq;

  always_comb begin
    unique case (1'b1)
      hit_ctrl: bus_rdata = ctrl_rd;
      hit_type: bus_rdata = TYPE_VAL;
      hit_grp:  bus_rdata = grp_rd;
      default:  bus_rdata = 8'h00;
    endcase
  end

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == 8'h00)); // R8
  AST_ERR_ONLY_GROUP: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_addr[ADDR_W-1:GRP_IDX_W] == (ADDR_W - GRP_IDX_W)'(1)); // R10
  AST_TYPE_CONST: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFS_TYPE)) |-> (bus_rdata == TYPE_VAL)); // R4

endmodule

// File: tb/irq_grp_dist_regs_bench.sv
module irq_grp_dist_regs_bench;
  localparam int unsigned LINES = 64;
  localparam int unsigned CORES = 2;
  localparam int unsigned AW    = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic [AW-1:0]  bus_addr;
  logic           bus_wr;
  logic [7:0]     bus_wdata;
  logic [7:0]     rdata, rdata_l;
  logic           err, err_l;
  logic           g0, g1, fq, g0_l, g1_l, fq_l;
  logic [LINES-1:0] lg, lg_l;

  int checks = 0;
  int fails  = 0;
  logic [LINES-1:0] exp_lg = '0;

  always #2 clk = ~clk;

  irq_grp_dist_regs #(.REVISION(2), .NUM_LINES(LINES), .NUM_CORES(CORES), .ADDR_W(AW)) u_irq_grp_dist_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .bus_err(err), .grp0_en(g0), .grp1_en(g1), .fiq_en(fq), .line_group(lg));

  irq_grp_dist_regs #(.REVISION(1), .NUM_LINES(LINES), .NUM_CORES(CORES), .ADDR_W(AW)) u_legacy (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_l), .bus_err(err_l), .grp0_en(g0_l), .grp1_en(g1_l), .fiq_en(fq_l), .line_group(lg_l));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input int unsigned a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_addr(input int unsigned a);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 grp0_en", 64'(g0), 64'd0);
    chk("R1 grp1_en", 64'(g1), 64'd0);
    chk("R1 fiq_en", 64'(fq), 64'd0);
    chk("R1 line_group", 64'(lg), 64'd0);
    set_addr(0);
    chk("R1 ctrl read", 64'(rdata), 64'd0);
    chk("R1 legacy ctrl read", 64'(rdata_l), 64'd0);
  endtask

  task automatic t_ctrl;
    wr_byte(0, 8'hFF);
    chk("R2 enables after FF", 64'({g0, g1, fq}), 64'b111);
    set_addr(0);
    chk("R2 ctrl readback FF", 64'(rdata), 64'h0B);
    chk("R3 legacy enables after FF", 64'({g0_l, g1_l, fq_l}), 64'b100);
    chk("R3 legacy readback FF", 64'(rdata_l), 64'h01);
    wr_byte(0, 8'h02);
    chk("R2 enables after 02", 64'({g0, g1, fq}), 64'b010);
    set_addr(0);
    chk("R2 ctrl readback 02", 64'(rdata), 64'h02);
    chk("R3 legacy after 02", 64'({g0_l, g1_l, fq_l}), 64'b000);
    wr_byte(0, 8'h09);
    chk("R2 enables after 09", 64'({g0, g1, fq}), 64'b101);
    set_addr(0);
    chk("R2 ctrl readback 09", 64'(rdata), 64'h09);
  endtask

  task automatic t_type;
    set_addr(4);
    chk("R4 type byte", 64'(rdata), 64'h21);
    chk("R10 err at type", 64'(err), 64'd0);
    wr_byte(4, 8'h00);
    set_addr(4);
    chk("R4 type after write", 64'(rdata), 64'h21);
    chk("R4 legacy type", 64'(rdata_l), 64'h21);
  endtask

  task automatic t_reserved;
    int unsigned offs[6] = '{1, 2, 3, 5, 6, 7};
    foreach (offs[k]) begin
      wr_byte(offs[k], 8'hF6);
      set_addr(offs[k]);
      chk("R5 reserved reads zero", 64'(rdata), 64'd0);
    end
    set_addr(0);
    chk("R5 ctrl unchanged", 64'(rdata), 64'h09);
    chk("R5 enables unchanged", 64'({g0, g1, fq}), 64'b101);
    chk("R10 err at ctrl", 64'(err), 64'd0);
  endtask

  task automatic t_group;
    wr_byte(12'h080, 8'hA5); exp_lg[7:0]   = 8'hA5;
    wr_byte(12'h087, 8'h3C); exp_lg[63:56] = 8'h3C;
    wr_byte(12'h083, 8'h01); exp_lg[31:24] = 8'h01;
    chk("R6 line_group map", 64'(lg), 64'(exp_lg));
    chk("R6 line 0 group1", 64'(lg[0]), 64'd1);
    chk("R6 line 24 group1", 64'(lg[24]), 64'd1);
    chk("R6 line 25 group0", 64'(lg[25]), 64'd0);
    set_addr(12'h087);
    chk("R6 readback 0x87", 64'(rdata), 64'h3C);
    chk("R10 err at 0x87", 64'(err), 64'd0);
    set_addr(12'h080);
    chk("R6 readback 0x80", 64'(rdata), 64'hA5);
    chk("R10 err at 0x80", 64'(err), 64'd0);
    chk("R7 legacy group read", 64'(rdata_l), 64'd0);
    chk("R7 legacy line_group", 64'(lg_l), 64'd0);
  endtask

  task automatic t_range;
    set_addr(12'h088);
    chk("R8 err at first missing byte", 64'(err), 64'd1);
    chk("R8 read zero beyond count", 64'(rdata), 64'd0);
    wr_byte(12'h088, 8'hFF);
    wr_byte(12'h0FF, 8'hFF);
    chk("R8 line_group unchanged", 64'(lg), 64'(exp_lg));
    set_addr(12'h0FF);
    chk("R8 err at last byte", 64'(err), 64'd1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    bus_addr = AW'(12'h081); bus_wdata = 8'h77; bus_wr = 1'b1;
    #1;
    chk("R9 same-cycle read old value", 64'(rdata), 64'h00);
    chk("R9 output before edge", 64'(lg[15:8]), 64'h00);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    exp_lg[15:8] = 8'h77;
    chk("R9 output after edge", 64'(lg[15:8]), 64'h77);
    chk("R9 read after edge", 64'(rdata), 64'h77);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_type();
    t_reserved();
    t_group();
    t_range();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule